// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the byte-wide register front end of an asynchronous serial controller. A host reaches it through a 3-bit address with separate read and write strobes. It stores the line format, the interrupt enables and a 16-bit baud divisor. It also keeps the received byte and the receive error flags, and it reports pending events through a prioritised identification code and a single interrupt request line. The shift engines and the baud tick generator live outside the block. They reach it through narrow status inputs: a received-byte strobe with its error flags, a transmitter-took-the-byte strobe, a shifter-idle level and a modem-change level. The block drives them through configuration outputs and a one-cycle load strobe with its byte.

Bit 7 of the line format register is a bank bit. When it is set, the two lowest addresses are remapped from the data and enable registers to the two divisor bytes. The divisor the host programs is the 1.8432 MHz reference over sixteen times the baud rate. For example, 0x000C gives 9600 baud and 0x0060 gives 1200 baud. The block stores that value and presents it to the tick generator unchanged.

Reads return data combinationally in the cycle the strobe is high. Any clearing side effect of a read takes place at the clock edge that ends the strobe.

Top module: `uart_regbank`

## Requirements
- R1: After reset the ID register (address 2) reads 0x01, the line status register (address 5) reads 0x60 while `tx_shift_idle` is high, the enable register and line format register read 0x00, `divisor` is 0, `cfg_line` is 0 and `irq` is low.
- R2: With bank bit (line format bit 7) clear, a read of address 0 returns the byte of the most recent `rx_strobe`. A write to address 0 makes `thr_load` high for exactly the one cycle after the write edge, with `thr_data` equal to the written byte. The same write clears line status bit 5, and a `tx_taken` pulse sets bit 5 again.
- R3: With the bank bit set, address 0 reads and writes `divisor[7:0]` and address 1 reads and writes `divisor[15:8]`. Such writes change neither the enable register nor the transmit path: no `thr_load` pulse follows them.
- R4: With the bank bit clear, address 1 is the enable register. Bit 0 enables received data, bit 1 transmit-empty, bit 2 line errors and bit 3 modem change. Bits 7:4 always read 0.
- R5: Address 3 reads back all 8 written bits, and `cfg_line` equals its bits 6:0.
- R6: Line status bit 0 (data ready) is set by `rx_strobe` and cleared by a read of address 0 with the bank bit clear. A strobe that arrives while data ready is already set sets bit 1 (overrun). Bit 6 follows `tx_shift_idle`.
- R7: Line status bits 2, 3 and 4 collect `rx_par_err`, `rx_frm_err` and `rx_brk` on each `rx_strobe`. A read of address 5 clears them and bit 1. Bit 7 reads 0.
- R8: The ID register reads 0x06 for a line error (bits 1..4 of line status, when enable bit 2 is set). Otherwise it reads 0x04 for data ready (enable bit 0), then 0x02 for transmit-empty pending (enable bit 1), then 0x00 for `modem_int` (enable bit 3), and 0x01 when nothing is pending.
- R9: Transmit-empty pending is set by `tx_taken`. It is also set by a write to the enable register that raises bit 1 while line status bit 5 is 1. It is cleared by a write to address 0 with the bank bit clear, or by a read of address 2 that returns 0x02.
- R10: `irq` is high exactly when the ID register would read with bit 0 at 0.
- R11: Addresses 4, 6 and 7 read 0x00 and ignore writes. Writes to address 2 and address 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd` is high |
| rx_strobe | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error on this byte |
| rx_frm_err | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Break detected with this byte |
| tx_taken | input | 1 | Transmitter moved the holding byte into its shifter |
| tx_shift_idle | input | 1 | Transmit shifter is empty |
| modem_int | input | 1 | Modem status change pending (level) |
| thr_load | output | 1 | One-cycle strobe: new transmit byte on `thr_data` |
| thr_data | output | 8 | Transmit holding byte |
| divisor | output | 16 | Baud divisor |
| cfg_line | output | 7 | Word length [1:0], stop bits [2], parity enable [3], even parity [4], stick parity [5], break [6] |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench compares `rdata` 1 ns after it raises `rd` on a falling edge, before the edge that commits the read. State changes caused by a write, a read or a status strobe appear 1 ns after the next rising edge. At that point the bench checks `irq`, `divisor`, `cfg_line` and the one-cycle `thr_load` pulse against its model, which has been updated with that same edge's effects. `thr_load` is due exactly one edge after the transmit write and is expected low at every other check. Random operations drawn from a fixed seed are issued one per cycle and never overlap, so every expected value follows from the requirements alone.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          rx_brk,
  input  logic          tx_taken,
  input  logic          tx_shift_idle,
  input  logic          modem_int,
  output logic          thr_load,
  output logic [DW-1:0] thr_data,
  output logic [2*DW-1:0] divisor,
  output logic [DW-2:0] cfg_line,
  output logic          irq
);
  localparam logic [DW-1:0] ID_NONE = DW'(8'h01);
  localparam logic [DW-1:0] ID_LINE = DW'(8'h06);
  localparam logic [DW-1:0] ID_RXD  = DW'(8'h04);
  localparam logic [DW-1:0] ID_THE  = DW'(8'h02);
  localparam logic [DW-1:0] ID_MOD  = DW'(8'h00);

  logic [DW-1:0] rbr, lcr, dll, dlm;
  logic [3:0]    ier;
  logic          dr, oe, pe, fe, bi, thre, thri;
  logic [DW-1:0] iir, lsr;

  wire dlab   = lcr[DW-1];
  wire a_dat  = (addr == AW'(0));
  wire a_ier  = (addr == AW'(1));
  wire wr_thr = wr && a_dat && !dlab;
  wire wr_dll = wr && a_dat && dlab;
  wire wr_ier = wr && a_ier && !dlab;
  wire wr_dlm = wr && a_ier && dlab;
  wire wr_lcr = wr && (addr == AW'(3));
  wire rd_rbr = rd && a_dat && !dlab;
  wire rd_iir = rd && (addr == AW'(2));
  wire rd_lsr = rd && (addr == AW'(5));
  wire err_any = oe | pe | fe | bi;

  always_comb begin
    if (ier[2] && err_any)     iir = ID_LINE;
    else if (ier[0] && dr)     iir = ID_RXD;
    else if (ier[1] && thri)   iir = ID_THE;
    else if (ier[3] && modem_int) iir = ID_MOD;
    else                       iir = ID_NONE;
  end

  assign lsr = {1'b0, tx_shift_idle, thre, bi, fe, pe, oe, dr};

  always_comb begin
    case (addr)
      AW'(0):  rdata = dlab ? dll : rbr;
      AW'(1):  rdata = dlab ? dlm : {4'b0, ier};
      AW'(2):  rdata = iir;
      AW'(3):  rdata = lcr;
      AW'(5):  rdata = lsr;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr <= '0; dll <= '0; dlm <= '0; ier <= '0;
    end else begin
      if (wr_lcr) lcr <= wdata;
      if (wr_dll) dll <= wdata;
      if (wr_dlm) dlm <= wdata;
      if (wr_ier) ier <= wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= '0; dr <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
    end else begin
      if (rd_rbr) dr <= 1'b0;
      if (rd_lsr) begin
        oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
      end
      if (rx_strobe) begin
        rbr <= rx_byte;
        dr  <= 1'b1;
        if (dr && !rd_rbr) oe <= 1'b1;
        if (rx_par_err) pe <= 1'b1;
        if (rx_frm_err) fe <= 1'b1;
        if (rx_brk)     bi <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre <= 1'b1; thri <= 1'b0; thr_load <= 1'b0; thr_data <= '0;
    end else begin
      thr_load <= wr_thr;
      if (wr_thr) begin
        thr_data <= wdata;
        thre     <= 1'b0;
      end else if (tx_taken) begin
        thre <= 1'b1;
      end
      if (wr_thr || (rd_iir && iir == ID_THE)) thri <= 1'b0;
      if (tx_taken || (wr_ier && wdata[1] && !ier[1] && thre)) thri <= 1'b1;
    end
  end

  assign divisor  = {dlm, dll};
  assign cfg_line = lcr[DW-2:0];
  assign irq      = ~iir[0];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rx_strobe,
  input logic       thr_load,
  input logic [7:0] thr_data,
  input logic       irq,
  input logic       dlab,
  input logic [3:0] ier,
  input logic       dr,
  input logic [3:0] errs
);
  p_thr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd0 && !dlab) |=> (thr_load && thr_data == $past(wdata)));

  p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd0 && dlab) |=> !thr_load);

  p_ier_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 3'd1 && !dlab) |-> (rdata[7:4] == 4'h0));

  p_dr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 3'd0 && !dlab && !rx_strobe) |=> !dr);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 3'd5 && !rx_strobe) |=> (errs == 4'h0));

  p_lsr_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 3'd5) |-> !rdata[7]);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'h0) |-> !irq);

  p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == 3'd4 || addr == 3'd6 || addr == 3'd7)) |-> (rdata == 8'h00));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
  .rdata(rdata), .rx_strobe(rx_strobe), .thr_load(thr_load), .thr_data(thr_data),
  .irq(irq), .dlab(lcr[7]), .ier(ier), .dr(dr), .errs({oe, pe, fe, bi})
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0, rx_byte = 0;
  logic rx_strobe = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
  logic tx_taken = 0, tx_shift_idle = 1, modem_int = 0;
  logic [7:0] rdata, thr_data;
  logic thr_load, irq;
  logic [15:0] divisor;
  logic [6:0] cfg_line;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_rbr = 0, m_lcr = 0, m_dll = 0, m_dlm = 0, m_thr = 0;
  logic [3:0] m_ier = 0;
  bit m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0, m_thre = 1, m_thri = 0, m_ld = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .rx_strobe(rx_strobe), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .tx_taken(tx_taken),
    .tx_shift_idle(tx_shift_idle), .modem_int(modem_int), .thr_load(thr_load),
    .thr_data(thr_data), .divisor(divisor), .cfg_line(cfg_line), .irq(irq)
  );

  function automatic logic [7:0] exp_iir();
    if (m_ier[2] && (m_oe | m_pe | m_fe | m_bi)) return 8'h06;
    if (m_ier[0] && m_dr) return 8'h04;
    if (m_ier[1] && m_thri) return 8'h02;
    if (m_ier[3] && modem_int) return 8'h00;
    return 8'h01;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : m_rbr;
      3'd1: return m_lcr[7] ? m_dlm : {4'h0, m_ier};
      3'd2: return exp_iir();
      3'd3: return m_lcr;
      3'd5: return {1'b0, tx_shift_idle, m_thre, m_bi, m_fe, m_pe, m_oe, m_dr};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic post_chk();
    chk("R10 irq", {15'b0, irq}, {15'b0, ~exp_iir()[0]});
    chk("R3 divisor", divisor, {m_dlm, m_dll});
    chk("R5 cfg_line", {9'b0, cfg_line}, {9'b0, m_lcr[6:0]});
    chk("R2 thr_load", {15'b0, thr_load}, {15'b0, m_ld});
    if (m_ld) chk("R2 thr_data", {8'b0, thr_data}, {8'b0, m_thr});
    m_ld = 0;
    @(negedge clk);
  endtask

  task automatic do_rd(input logic [2:0] a, input string req);
    logic [7:0] e;
    addr = a; rd = 1; #1;
    e = exp_rd(a);
    chk(req, {8'b0, rdata}, {8'b0, e});
    @(posedge clk); #1; rd = 0;
    case (a)
      3'd0: if (!m_lcr[7]) m_dr = 0;
      3'd2: if (e == 8'h02) m_thri = 0;
      3'd5: begin m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; end
      default: ;
    endcase
    post_chk();
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); #1; wr = 0;
    case (a)
      3'd0: if (m_lcr[7]) m_dll = d;
            else begin m_thr = d; m_ld = 1; m_thre = 0; m_thri = 0; end
      3'd1: if (m_lcr[7]) m_dlm = d;
            else begin
              if (d[1] && !m_ier[1] && m_thre) m_thri = 1;
              m_ier = d[3:0];
            end
      3'd3: m_lcr = d;
      default: ;
    endcase
    post_chk();
  endtask

  task automatic do_rx(input logic [7:0] b, input bit p, input bit f, input bit k);
    rx_byte = b; rx_par_err = p; rx_frm_err = f; rx_brk = k; rx_strobe = 1;
    @(posedge clk); #1; rx_strobe = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0;
    if (m_dr) m_oe = 1;
    m_rbr = b; m_dr = 1;
    if (p) m_pe = 1;
    if (f) m_fe = 1;
    if (k) m_bi = 1;
    post_chk();
  endtask

  task automatic do_take();
    tx_taken = 1;
    @(posedge clk); #1; tx_taken = 0;
    m_thre = 1; m_thri = 1;
    post_chk();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 divisor", divisor, 16'h0);
    chk("R1 cfg_line", {9'b0, cfg_line}, 16'h0);
    do_rd(3'd2, "R1 iir");
    do_rd(3'd5, "R1 lsr");
    do_rd(3'd1, "R1 ier");
    do_rd(3'd3, "R1 lcr");
    // R3 divisor banking: 9600 baud
    do_wr(3'd3, 8'h83);
    do_wr(3'd0, 8'h0C);
    do_wr(3'd1, 8'h00);
    do_rd(3'd0, "R3 dll");
    do_wr(3'd1, 8'hFF);
    do_rd(3'd1, "R3 dlm");
    do_wr(3'd3, 8'h03);
    do_rd(3'd1, "R3 ier untouched");
    // R4 upper bits read zero
    do_wr(3'd1, 8'hF0);
    do_rd(3'd1, "R4 ier upper");
    do_wr(3'd1, 8'h00);
    // R2/R6 receive and overrun
    do_rx(8'hA5, 0, 0, 0);
    do_rd(3'd5, "R6 data ready");
    do_rx(8'h3C, 1, 0, 1);
    do_rd(3'd5, "R6 overrun R7 errors");
    do_rd(3'd5, "R7 errors cleared");
    do_rd(3'd0, "R2 rbr");
    do_rd(3'd5, "R6 dr cleared");
    // R8 priority ladder
    do_wr(3'd1, 8'h0F);
    modem_int = 1; #1;
    do_rd(3'd2, "R8 thre pending via enable");
    do_rd(3'd2, "R8 modem after thre cleared");
    do_rx(8'h11, 0, 1, 0);
    do_rd(3'd2, "R8 line top");
    do_rd(3'd5, "R7 clear");
    do_rd(3'd2, "R8 rx data");
    do_rd(3'd0, "R2 rbr 11");
    // R9 transmit path
    do_wr(3'd0, 8'h5A);
    do_rd(3'd5, "R2 thre low");
    do_take();
    do_rd(3'd5, "R2 thre high");
    do_rd(3'd2, "R9 thre reported");
    modem_int = 0; #1;
    do_rd(3'd2, "R9 thre cleared");
    do_take();
    do_wr(3'd0, 8'h77);
    do_rd(3'd2, "R9 cleared by write");
    // R11 unused addresses
    do_wr(3'd4, 8'hFF); do_wr(3'd6, 8'hFF); do_wr(3'd7, 8'hFF);
    do_wr(3'd2, 8'hFF); do_wr(3'd5, 8'hFF);
    do_rd(3'd4, "R11 a4"); do_rd(3'd6, "R11 a6"); do_rd(3'd7, "R11 a7");
    do_rd(3'd5, "R11 lsr after write");
    tx_shift_idle = 0; #1;
    do_rd(3'd5, "R6 shifter busy");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k == 0) begin
        modem_int = $urandom_range(0, 1);
        tx_shift_idle = $urandom_range(0, 1);
        #1;
      end
      case (k)
        0, 1, 2, 3: do_rd(3'($urandom_range(0, 7)), "R8 random read");
        4, 5: do_wr(3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
        6: do_wr(3'd3, {$urandom_range(0, 3) == 0, 7'($urandom_range(0, 127))});
        7, 8: do_rx(8'($urandom_range(0, 255)), $urandom_range(0, 7) == 0,
                    $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
        default: do_take();
      endcase
    end
    summary();
  end
endmodule